// File: doc/BRIEF.md
# Dual-Channel Edge Capture Timer

This block timestamps transitions on two digital input pins. Each pin owns two capture registers, one for rising transitions and one for falling transitions. When a transition is detected, the register for that pin and direction takes the value of a shared 8-bit timebase. The timebase runs freely, and its step rate is set by a 3-bit prescale field. Software reaches the block over a small single-cycle register port. Through it, software reads the four timestamps and a status word, and reads or writes one configuration word.

By default, every qualifying transition overwrites its register, so a read returns the most recent timestamp. A single global hold mode changes this for all four registers at once. In hold mode, a register keeps the first timestamp it took and ignores later transitions until software reads it. Each register has an event flag. A read of that register clears its flag. An interrupt request is raised from the flags that software has enabled.

The register port has no back-pressure. A read or a write completes in the cycle its strobe is high. Read data is presented combinationally in that same cycle, and the side effects of the read take hold at the next clock edge.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, all four capture registers, the configuration word, the status word and the timebase are zero, and `irq` is low.
- R2: The capture registers sit at these offsets: pin A rising at 0, pin A falling at 1, pin B rising at 2, pin B falling at 3. Each is written only by transitions of its own pin and direction. Both inputs are passed through a two-flop synchronizer, so every transition reaches its register with the same latency.
- R3: When hold mode is off, each qualifying transition overwrites its register. The value read is the timebase at the most recent transition.
- R4: When configuration bit 7 is set, hold mode applies to all four registers. A register whose flag is set keeps its value, and further transitions do not change it until that register is read.
- R5: With configuration bits 6:4 equal to n, the 8-bit timebase advances once every 2^n clocks and wraps from 255 to 0. Two transitions 40 clocks apart at n=2 therefore differ by exactly 10.
- R6: The configuration word at offset 4 is writable and reads back as written. Its fields are: bit 7 hold mode, bits 6:4 prescale, bits 3:0 interrupt enables (bit 0 A rising, bit 1 A falling, bit 2 B rising, bit 3 B falling).
- R7: The status word at offset 5 carries the event flags in the same bit order as the enables, and its bits 7:4 read zero. Offsets 6 and 7 read zero.
- R8: A read of a capture register clears its flag and, in hold mode, releases the hold, both at the next clock edge.
- R9: A transition that is captured in the same cycle as a read of its register is still captured, and its flag stays set.
- R10: `irq` is high exactly when some event flag is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | Asynchronous input pin A |
| pin_b | input | 1 | Asynchronous input pin B |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a transition that lands in the very cycle its own register is being read. The stimulus counts the synchronizer stages: it raises the pin and waits exactly two clock edges, then issues the read, so the detect cycle and the read strobe coincide. Absolute timestamps depend on the timebase phase. For that reason, every timestamp is checked as a difference from another register captured at a known cycle distance, and this also covers prescaled rates, hold-mode freezing and the release after a read.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int TB_W   = 8;
  localparam int PS_W   = 3;
  localparam int NPIN   = 2;
  localparam int NSLOT  = 2 * NPIN;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = (1 << PS_W) - 1;

  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(5);

  typedef struct packed {
    logic             hold;
    logic [PS_W-1:0]  ps;
    logic [NSLOT-1:0] ien;
  } cfg_t;
endpackage

// File: rtl/ect_pin_edge.sv
module ect_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ect_timebase.sv
module ect_timebase
  import ect_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PS_W-1:0] ps,
  output logic [TB_W-1:0] count
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             tick;

  assign mask = ~({DIV_W{1'b1}} << ps);
  assign tick = &(div_q | ~mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      count <= '0;
    end else begin
      div_q <= div_q + 1'b1;
      if (tick) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ect_slot.sv
module ect_slot
  import ect_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            edge_hit,
  input  logic            rd_hit,
  input  logic            hold,
  input  logic [TB_W-1:0] tb,
  output logic [TB_W-1:0] cap,
  output logic            flag
);
  logic frozen;
  logic take;

  assign frozen = hold & flag & ~rd_hit;
  assign take   = edge_hit & ~frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap  <= '0;
      flag <= 1'b0;
    end else begin
      if (take) cap <= tb;
      if (take || (edge_hit && flag)) flag <= 1'b1;
      else if (rd_hit)                flag <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq
);
  cfg_t                  cfg_q;
  logic [TB_W-1:0]       tb;
  logic [NPIN-1:0]       pins;
  logic [NSLOT-1:0]      edges;
  logic [NSLOT-1:0]      flags;
  logic [NSLOT-1:0]      rd_hit;
  logic [NSLOT*TB_W-1:0] cap_flat;

  assign pins = {pin_b, pin_a};

  always_ff @(posedge clk) begin
    if (!rst_n)                           cfg_q <= '0;
    else if (reg_wr && reg_addr == OFS_CFG) cfg_q <= cfg_t'(reg_wdata);
  end

  ect_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .ps(cfg_q.ps), .count(tb)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    ect_pin_edge #(.STAGES(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(pins[p]),
      .rise(edges[2*p]), .fall(edges[2*p+1])
    );
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign rd_hit[s] = reg_rd && (reg_addr == ADDR_W'(s));
    ect_slot u_slot (
      .clk(clk), .rst_n(rst_n), .edge_hit(edges[s]), .rd_hit(rd_hit[s]),
      .hold(cfg_q.hold), .tb(tb),
      .cap(cap_flat[s*TB_W +: TB_W]), .flag(flags[s])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDR_W'(NSLOT))
      reg_rdata = cap_flat[reg_addr*TB_W +: TB_W];
    else if (reg_addr == OFS_CFG)
      reg_rdata = cfg_q;
    else if (reg_addr == OFS_STAT)
      reg_rdata = 8'(flags);
  end

  assign irq = |(flags & cfg_q.ien);
endmodule

// File: rtl/ect_checker.sv
module ect_checker
  import ect_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq,
  input logic                  reg_rd,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [7:0]            reg_rdata,
  input logic                  hold,
  input logic [NSLOT-1:0]      flags,
  input logic [NSLOT-1:0]      edges,
  input logic [NSLOT-1:0]      rd_hit,
  input logic [NSLOT*TB_W-1:0] cap_flat
);
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R10
  AST_STATUS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_STAT) |-> (reg_rdata[7:4] == 4'h0)); // R7

  for (genvar s = 0; s < NSLOT; s++) begin : g_chk
    AST_HOLD_KEEPS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && flags[s] && !rd_hit[s]) |=> $stable(cap_flat[s*TB_W +: TB_W])); // R4
    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[s] && !edges[s]) |=> !flags[s]); // R8
    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      edges[s] |=> flags[s]); // R9
  end
endmodule

bind edge_capture_timer ect_checker u_ect_checker (
  .clk(clk), .rst_n(rst_n), .irq(irq), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .hold(cfg_q.hold), .flags(flags), .edges(edges),
  .rd_hit(rd_hit), .cap_flat(cap_flat)
);

// File: tb/edge_capture_timer_bench.sv
`timescale 1ns/100ps
module edge_capture_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_a = 1'b0, pin_b = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0, raw_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;
  int         n_run = 0, n_fail = 0;

  typedef struct { logic [2:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  edge_capture_timer u_edge_capture_timer (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compares checked reads against the scoreboard queue
  always @(negedge clk) begin
    if (reg_rd && !raw_rd) begin
      item_t it;
      it = sb_q.pop_front();
      n_run++;
      if (reg_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=%0d actual=%02h expected=%02h", it.tag, it.addr, reg_rdata, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    reg_addr = a; reg_rd = 1'b1;
    step(1);
    reg_rd = 1'b0;
  endtask

  task automatic rd_raw(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1; raw_rd = 1'b1;
    @(negedge clk) v = reg_rdata;
    step(1);
    reg_rd = 1'b0; raw_rd = 1'b0;
  endtask

  task automatic wr_cfg(input logic [7:0] d);
    reg_addr = 3'd4; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    n_run++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
    step(1);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1: reset state
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'h00, "R1 reset value");
    chk_irq(1'b0, "R1 reset irq");

    // R2 R3: overwrite mode, prescale 0
    pin_a = 1'b1; step(20);
    pin_a = 1'b0; step(30);
    pin_a = 1'b1; step(6);
    rd_chk(3'd5, 8'h03, "R7 status after A edges");
    rd_raw(3'd1, v);
    rd_chk(3'd0, v + 8'd30, "R3 latest rise overwrites");
    rd_chk(3'd5, 8'h00, "R8 flags cleared by reads");
    rd_chk(3'd2, 8'h00, "R2 B rise untouched by pin A");

    // R10: only A-fall enabled
    wr_cfg(8'h02);
    pin_a = 1'b0; step(6);
    chk_irq(1'b1, "R10 enabled A fall flag");
    rd_raw(3'd1, v);
    chk_irq(1'b0, "R10 cleared enabled flag");
    pin_a = 1'b1; step(6);
    chk_irq(1'b0, "R10 disabled A rise flag");
    rd_raw(3'd0, v);

    // R5: prescale n=2
    wr_cfg(8'h20);
    rd_chk(3'd4, 8'h20, "R6 config readback");
    pin_a = 1'b0; step(40);
    pin_a = 1'b1; step(6);
    rd_raw(3'd1, v);
    rd_chk(3'd0, v + 8'd10, "R5 prescale 4-clock steps");

    // R9: transition meeting a read of its own register
    wr_cfg(8'h00);
    pin_a = 1'b0; step(8);
    rd_raw(3'd1, v);
    pin_a = 1'b1; step(2);
    rd_raw(3'd0, v);
    step(3);
    rd_chk(3'd5, 8'h01, "R9 flag kept on read collision");
    rd_raw(3'd0, v);

    // R4: global hold mode, pin B then pin A
    wr_cfg(8'h80);
    pin_b = 1'b1; step(10);
    pin_b = 1'b0; step(30);
    pin_b = 1'b1; step(6);
    rd_raw(3'd3, v);
    rd_chk(3'd2, v - 8'd10, "R4 B rise holds first edge");
    pin_a = 1'b0; step(10);
    pin_a = 1'b1; step(25);
    pin_a = 1'b0; step(6);
    rd_raw(3'd0, v);
    rd_chk(3'd1, v - 8'd10, "R4 A fall holds first edge");
    // R8: release after read
    pin_b = 1'b0; step(15);
    pin_b = 1'b1; step(6);
    rd_raw(3'd3, v);
    rd_chk(3'd2, v + 8'd15, "R8 hold released by read");

    rd_chk(3'd5, 8'h00, "R7 status clear");
    rd_chk(3'd6, 8'h00, "R7 offset 6 zero");
    rd_chk(3'd7, 8'h00, "R7 offset 7 zero");
    rd_chk(3'd4, 8'h80, "R6 config hold readback");

    step(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule